// File: doc/BRIEF.md
# TDM Receive Time-Slot Gate

This block sits behind a serial receiver on a framed time-division multiplexed line and keeps only the bits that belong to one channel. One data bit arrives per receive clock, and a frame sync pulse marks where each frame begins. The block counts bit positions from that pulse. It then decides, bit by bit, whether the current position falls inside the channel's share of the frame. Accepted bits leave one clock later with a valid strobe. A start marker flags the first bit of every active window.

The placement is coarse plus fine: a 7-bit slot number picks an octet boundary and a 3-bit shift moves the window by single bits. In window mode the block takes one contiguous run of programmable length. In mask mode it lays a grid of fixed 8-bit slots from the same offset. A 32-bit mask then chooses which of those slots are taken. Configuration is captured on the frame sync clock, so a change made mid-frame only applies from the next frame. Decoding of the framing carried on the channel happens downstream.

Top module: `tdm_rx_slot_gate`

## Requirements
- R1: On the clock where `frame_sync` is high the sampled bit is at position 0, and each later clock advances the position by one. The position stops at 1023 and stays there until the next sync. No bit is accepted at position 0, at position 1023, or before the first sync after reset.
- R2: The first accepted position of the channel is offset = 1 + 8*`cfg_slot` + `cfg_shift`, which spans 1 to 1024.
- R3: With `cfg_mask_en` = 0, the block accepts exactly `cfg_cap` + 1 consecutive positions starting at the offset.
- R4: With `cfg_mask_en` = 1, every slot is 8 positions wide and `cfg_cap` has no effect on the output.
- R5: In mask mode, slot n covers positions offset+8n to offset+8n+7 for n from 0 to 31. A slot is accepted only when `cfg_mask[n]` is 1. Positions at or beyond offset+256 are never accepted.
- R6: The configuration inputs are captured only on a clock with `frame_sync` high. Changes between syncs do not affect the current frame.
- R7: A window that reaches past position 1022 is cut there. An offset of 1023 or 1024 produces no accepted bit.
- R8: A bit sampled on an accepted position appears on `out_data` with `out_valid` high one clock later. When `out_valid` is low, `out_data` is 0.
- R9: `out_start` is high together with `out_valid` on the first bit of each window. In window mode that is the offset position. In mask mode it is the first position of every accepted slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, one data bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | One-clock frame start pulse |
| rx_data | input | 1 | Serial receive data |
| cfg_slot | input | 7 | Coarse slot number, in octets |
| cfg_shift | input | 3 | Fine shift, in bits |
| cfg_cap | input | 9 | Window length minus one (window mode) |
| cfg_mask_en | input | 1 | 1 selects mask mode, 0 window mode |
| cfg_mask | input | 32 | Per-octet-slot enable for mask mode |
| out_valid | output | 1 | Accepted bit strobe |
| out_data | output | 1 | Accepted bit value |
| out_start | output | 1 | First bit of an active window |

## Verification
The assertions take for granted that `frame_sync` is a clean single-clock pulse that is not held high across frames. They also assume `rx_data` and the configuration are stable around the sampling edge. The bench changes every input only at the falling clock edge. It uses single-cycle sync pulses and frames from 20 to 1100 clocks long, so that saturation of the position counter is reached. It also changes the configuration mid-frame on purpose, which the latching rule must absorb.

// File: rtl/tdm_gate_pkg.sv
package tdm_gate_pkg;

    localparam int SLOT_W    = 7;
    localparam int SHIFT_W   = 3;
    localparam int CAP_W     = 9;
    localparam int NUM_SLOTS = 32;
    localparam int POS_W     = 10;
    localparam int OCTET     = 8;

    localparam int OCT_SH    = $clog2(OCTET);
    localparam int WIDE_W    = POS_W + 2;
    localparam int POS_MAX   = (1 << POS_W) - 1;

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [WIDE_W-1:0] wide_t;

    typedef enum logic {
        MODE_WINDOW = 1'b0,
        MODE_MASK   = 1'b1
    } gate_mode_e;

    typedef struct packed {
        logic [SLOT_W-1:0]    slot;
        logic [SHIFT_W-1:0]   shift;
        logic [CAP_W-1:0]     cap;
        gate_mode_e           mode;
        logic [NUM_SLOTS-1:0] mask;
    } gate_cfg_t;

    typedef struct packed {
        logic valid;
        logic data;
        logic start;
    } gate_out_t;

    function automatic wide_t window_offset(input gate_cfg_t c);
        return wide_t'(1) + (wide_t'(c.slot) << OCT_SH) + wide_t'(c.shift);
    endfunction

    function automatic wide_t window_end(input gate_cfg_t c);
        return window_offset(c) + wide_t'(c.cap) + wide_t'(1);
    endfunction

endpackage

// File: rtl/tdm_pos_counter.sv
module tdm_pos_counter
    import tdm_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_sync,
    output pos_t pos
);
    pos_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= pos_t'(POS_MAX);
        end else if (frame_sync) begin
            cnt_q <= pos_t'(1);
        end else if (cnt_q != pos_t'(POS_MAX)) begin
            cnt_q <= cnt_q + pos_t'(1);
        end
    end

    assign pos = cnt_q;

    AST_POS_RESTART: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> (pos == pos_t'(1)));                       // R1
    AST_POS_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (!frame_sync && pos == pos_t'(POS_MAX)) |=> (pos == pos_t'(POS_MAX))); // R1
endmodule

// File: rtl/tdm_cfg_latch.sv
module tdm_cfg_latch
    import tdm_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frame_sync,
    input  gate_cfg_t cfg_in,
    output gate_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (frame_sync) begin
            cfg_q <= cfg_in;
        end
    end

    AST_CFG_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
        !frame_sync |=> $stable(cfg_q));                         // R6
endmodule

// File: rtl/tdm_slot_decode.sv
module tdm_slot_decode
    import tdm_gate_pkg::*;
(
    input  pos_t      pos,
    input  logic      frame_sync,
    input  gate_cfg_t cfg,
    output logic      accept,
    output logic      first
);
    wide_t                 off;
    wide_t                 p;
    wide_t                 rel;
    wide_t                 slot_idx;
    logic                  in_frame;
    logic                  after_off;
    logic                  win_hit;
    logic                  win_first;
    logic [NUM_SLOTS-1:0]  slot_hit;
    logic                  mask_hit;
    logic                  mask_first;

    always_comb begin
        off       = window_offset(cfg);
        p         = wide_t'(pos);
        in_frame  = !frame_sync && (pos != pos_t'(POS_MAX));
        after_off = (p >= off);
        rel       = p - off;
        slot_idx  = rel >> OCT_SH;
        win_hit   = after_off && (p < window_end(cfg));
        win_first = (p == off);
        mask_first = (rel[OCT_SH-1:0] == '0);
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign slot_hit[g] = after_off && (slot_idx == wide_t'(g)) && cfg.mask[g];
    end

    assign mask_hit = |slot_hit;

    always_comb begin
        if (cfg.mode == MODE_MASK) begin
            accept = in_frame && mask_hit;
            first  = in_frame && mask_hit && mask_first;
        end else begin
            accept = in_frame && win_hit;
            first  = in_frame && win_hit && win_first;
        end
    end
endmodule

// File: rtl/tdm_rx_slot_gate.sv
module tdm_rx_slot_gate
    import tdm_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_sync,
    input  logic        rx_data,
    input  logic [6:0]  cfg_slot,
    input  logic [2:0]  cfg_shift,
    input  logic [8:0]  cfg_cap,
    input  logic        cfg_mask_en,
    input  logic [31:0] cfg_mask,
    output logic        out_valid,
    output logic        out_data,
    output logic        out_start
);
    gate_cfg_t cfg_in;
    gate_cfg_t cfg_cur;
    pos_t      pos;
    logic      accept;
    logic      first;
    gate_out_t out_q;

    always_comb begin
        cfg_in.slot  = cfg_slot;
        cfg_in.shift = cfg_shift;
        cfg_in.cap   = cfg_cap;
        cfg_in.mode  = cfg_mask_en ? MODE_MASK : MODE_WINDOW;
        cfg_in.mask  = cfg_mask;
    end

    tdm_pos_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .pos        (pos)
    );

    tdm_cfg_latch u_cfg (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .cfg_in     (cfg_in),
        .cfg_q      (cfg_cur)
    );

    tdm_slot_decode u_dec (
        .pos        (pos),
        .frame_sync (frame_sync),
        .cfg        (cfg_cur),
        .accept     (accept),
        .first      (first)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= accept;
            out_q.data  <= accept & rx_data;
            out_q.start <= first;
        end
    end

    assign out_valid = out_q.valid;
    assign out_data  = out_q.data;
    assign out_start = out_q.start;

    AST_NO_BIT_AT_SYNC: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> !out_valid);                               // R1
    AST_NO_BIT_AT_END: assert property (@(posedge clk) disable iff (rst)
        (pos == pos_t'(POS_MAX)) |=> !out_valid);                 // R7
    AST_DATA_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data == $past(rx_data)));              // R8
    AST_DATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_data);                                // R8
    AST_START_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        out_start |-> out_valid);                                 // R9
endmodule

// File: tb/tdm_rx_slot_gate_tb.sv
module tdm_rx_slot_gate_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_sync = 1'b0;
    logic        rx_data = 1'b0;
    logic [6:0]  cfg_slot = '0;
    logic [2:0]  cfg_shift = '0;
    logic [8:0]  cfg_cap = '0;
    logic        cfg_mask_en = 1'b0;
    logic [31:0] cfg_mask = '0;
    logic        out_valid, out_data, out_start;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    done = 0;
    string cur_req = "R1";

    int       m_pos = 1023;
    int       m_slot = 0, m_shift = 0, m_cap = 0;
    bit       m_men = 0;
    bit [31:0] m_mask = '0;
    bit       e_v = 0, e_d = 0, e_s = 0;
    int       frame_cnt = 0;

    always #4 clk = ~clk;

    tdm_rx_slot_gate u_dut (
        .clk(clk), .rst(rst), .frame_sync(frame_sync), .rx_data(rx_data),
        .cfg_slot(cfg_slot), .cfg_shift(cfg_shift), .cfg_cap(cfg_cap),
        .cfg_mask_en(cfg_mask_en), .cfg_mask(cfg_mask),
        .out_valid(out_valid), .out_data(out_data), .out_start(out_start)
    );

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, fails);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                fails++;
                $display("FAIL watchdog: got cycle %0d expected below 150000", cyc);
                summary();
                $finish;
            end
        end
    end

    task automatic model_step(input bit fs, input bit d);
        int p, off, rel;
        if (rst) begin
            m_pos = 1023; e_v = 0; e_d = 0; e_s = 0;
            return;
        end
        p   = fs ? 0 : m_pos;
        off = 1 + m_slot * 8 + m_shift;
        rel = p - off;
        e_v = 0; e_s = 0;
        if (p >= 1 && p <= 1022 && p >= off) begin
            if (!m_men) begin
                e_v = (p < off + m_cap + 1);
                e_s = e_v && (p == off);
            end else if (rel / 8 < 32) begin
                e_v = m_mask[rel / 8];
                e_s = e_v && (rel % 8 == 0);
            end
        end
        e_d = e_v & d;
        if (fs) begin
            m_slot = cfg_slot; m_shift = cfg_shift; m_cap = cfg_cap;
            m_men = cfg_mask_en; m_mask = cfg_mask;
            m_pos = 1;
        end else if (m_pos < 1023) begin
            m_pos++;
        end
    endtask

    task automatic tick(input bit fs);
        frame_sync = fs;
        rx_data = 1'($urandom_range(0, 1));
        @(posedge clk);
        model_step(fs, rx_data);
        #1;
        checks++;
        if ({out_valid, out_data, out_start} !== {e_v, e_d, e_s}) begin
            fails++;
            $display("FAIL %s: valid/data/start got %b%b%b expected %b%b%b (pos %0d)",
                     cur_req, out_valid, out_data, out_start, e_v, e_d, e_s, m_pos);
        end
        if (out_valid) frame_cnt++;
        @(negedge clk);
    endtask

    function automatic int min3(input int a, input int b, input int c);
        int m = a;
        if (b < m) m = b;
        if (c < m) m = c;
        return m;
    endfunction

    function automatic int expected_count(input int len);
        int off, hi, lo, n;
        off = 1 + m_slot * 8 + m_shift;
        n = 0;
        if (!m_men) begin
            hi = min3(off + m_cap + 1, 1023, len);
            if (hi > off) n = hi - off;
        end else begin
            for (int s = 0; s < 32; s++) begin
                if (m_mask[s]) begin
                    lo = off + 8 * s;
                    hi = min3(lo + 8, 1023, len);
                    if (hi > lo) n += hi - lo;
                end
            end
        end
        return n;
    endfunction

    task automatic run_frame(input int len, input int chg_at);
        int exp_n;
        frame_cnt = 0;
        tick(1'b1);
        for (int i = 1; i < len; i++) begin
            if (i == chg_at) begin
                cfg_slot = 7'($urandom); cfg_shift = 3'($urandom);
                cfg_cap = 9'($urandom); cfg_mask_en = ~cfg_mask_en;
                cfg_mask = $urandom;
            end
            tick(1'b0);
        end
        exp_n = expected_count(len);
        checks++;
        if (frame_cnt != exp_n) begin
            fails++;
            $display("FAIL %s: accepted bits got %0d expected %0d", cur_req, frame_cnt, exp_n);
        end
    endtask

    task automatic set_cfg(input int sl, input int sh, input int cp,
                           input bit men, input bit [31:0] mk);
        cfg_slot = 7'(sl); cfg_shift = 3'(sh); cfg_cap = 9'(cp);
        cfg_mask_en = men; cfg_mask = mk;
    endtask

    initial begin
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 3; i++) tick(1'b0);
        cur_req = "R1";
        checks++;
        if ({out_valid, out_data, out_start} !== 3'b000) begin
            fails++;
            $display("FAIL R1: reset outputs got %b%b%b expected 000", out_valid, out_data, out_start);
        end
        rst = 1'b0;
        set_cfg(0, 0, 7, 0, '0);
        for (int i = 0; i < 30; i++) tick(1'b0);       // R1: no sync yet, nothing accepted

        cur_req = "R2/R3";
        run_frame(40, -1);
        set_cfg(3, 5, 12, 0, '0);
        run_frame(60, -1);
        cur_req = "R3";
        set_cfg(2, 1, 0, 0, '0);
        run_frame(30, -1);
        run_frame(30, -1);

        cur_req = "R4/R5/R9";
        set_cfg(1, 2, 100, 1, 32'h0000_00A5);
        run_frame(300, -1);
        set_cfg(0, 0, 3, 1, 32'hC000_0003);
        run_frame(300, -1);
        set_cfg(0, 7, 511, 1, 32'hFFFF_FFFF);
        run_frame(300, -1);

        cur_req = "R7";
        set_cfg(100, 0, 0, 1, 32'hFFFF_FFFF);
        run_frame(1100, -1);
        set_cfg(127, 7, 511, 0, '0);
        run_frame(1100, -1);
        set_cfg(127, 6, 20, 0, '0);
        run_frame(1100, -1);
        set_cfg(120, 3, 511, 0, '0);
        run_frame(1100, -1);

        cur_req = "R6";
        set_cfg(4, 3, 40, 0, '0);
        run_frame(120, 10);
        set_cfg(2, 0, 0, 1, 32'h0000_0F0F);
        run_frame(150, 25);

        cur_req = "R8/R9";
        for (int f = 0; f < 20; f++) begin
            set_cfg(($urandom_range(0, 3) == 0) ? $urandom_range(0, 127) : $urandom_range(0, 20),
                    $urandom_range(0, 7), $urandom_range(0, 511),
                    1'($urandom_range(0, 1)), $urandom);
            run_frame($urandom_range(20, 1100), $urandom_range(0, 1) ? $urandom_range(2, 19) : -1);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule